// File: doc/BRIEF.md
# Boundary-Scan Test Access Port for a Synchronous Memory

This block is the serial test port of a synchronous memory device. An external tester drives a test clock, a mode-select line and a serial data input. The block walks the usual sixteen-state test controller and holds a 3-bit instruction. It places one of three data registers between the serial input and the serial output: a 1-bit bypass stage, a 32-bit identification word, or a 75-bit boundary register. The boundary register captures a parallel snapshot of the device I/O ring.

The instruction set is reduced and departs from the standard one. The two capture-and-isolate instructions never drive pins. They capture the I/O ring and raise a signal that puts every memory output driver into high impedance. The plain sample instruction captures the ring but leaves the memory alone, and data shifted into the boundary register never reaches any pin. Unused instruction codes act as the bypass instruction. The serial output changes on the falling edge of the test clock and is driven only while a shift state is active.

Top module: `scan_port`

## Requirements
- R1: With `trst_n` low at a rising `tck` edge, the controller goes to Test-Logic-Reset and the instruction becomes identify (001). After that edge `tdo_en` is 0, `tdo` is high-Z and `hiz_force` is 0.
- R2: Five rising edges with `tms` high bring the controller to Test-Logic-Reset from any state, and the current instruction becomes identify (001). After only four such edges the previous instruction still holds.
- R3: In Capture-IR the instruction shifter loads 001. In Shift-IR that value leaves on `tdo` LSB first, so the tester reads 1, 0, 0.
- R4: The current instruction changes only on the edge that leaves Update-IR, or when entering Test-Logic-Reset. Shifting a new code leaves `hiz_force` unchanged until the update.
- R5: Under identify (001), Capture-DR loads a 32-bit word that Shift-DR sends out LSB first. The fields are: bit 0 = 1; bits 11:1 = manufacturer code (default 00000101100); bits 17:12 = device field (default 0); bits 22:18 = width code (default 00011); bits 27:23 = depth code (default 00111); bits 31:28 = revision (default 0000).
- R6: Code 111, and the unused codes 011, 101 and 110, select the 1-bit bypass stage. It captures 0, so `tdo` gives 0 first and then each `tdi` bit delayed by one shift. `hiz_force` stays 0.
- R7: Code 100 captures `io_ring` into the 75-bit boundary register and shifts it out LSB first (bit 0 first), with `hiz_force` at 0.
- R8: Codes 000 and 010 capture `io_ring` and shift it out in the same way as R7. `hiz_force` is 1 for as long as either code is the current instruction.
- R9: `tdo` and `tdo_en` change only on falling `tck` edges. `tdo_en` is 1 exactly while the controller is in Shift-DR or Shift-IR, and `tdo` is high-Z otherwise.
- R10: `bsr_capture` is 1 during Capture-DR when the boundary register is selected (codes 000, 010, 100), and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Active-low test reset, sampled on rising tck |
| tms | input | 1 | Mode select, sampled on rising tck |
| tdi | input | 1 | Serial data in, sampled on rising tck |
| io_ring | input | BSR_LEN | Parallel I/O ring snapshot for the boundary register |
| tdo | output | 1 | Serial data out, high-Z when not shifting |
| tdo_en | output | 1 | Output enable for tdo |
| hiz_force | output | 1 | Forces all memory output drivers to high-Z |
| bsr_capture | output | 1 | Boundary-capture strobe toward the core |

## Verification
The bench first confirms that reset and the five-ones escape both leave the identify instruction in place. It then checks that four ones are not enough to clear an isolating instruction. A design that counted the ones wrongly would either drop `hiz_force` too early or leave the memory isolated after the escape.

Each shifted stream is compared bit by bit, in order, against values worked out independently. An off-by-one shift, a reversed bit order or a wrong ID field shows up as a mismatch at a known bit position. The bypass stream must begin with its captured 0.

The bench also samples `hiz_force` after a new code has been shifted but before the update. A design that applies the instruction early changes `hiz_force` there. Finally, a reserved code is loaded, which catches a decoder that treats unused codes as isolating instructions.

// File: rtl/scan_pkg.sv
// Shared types for the memory test access port.
// Assumes a 3-bit instruction register; codes are fixed by the tester protocol.
package scan_pkg;

    typedef enum logic [3:0] {
        ST_RESET   = 4'd0,
        ST_IDLE    = 4'd1,
        ST_SEL_DR  = 4'd2,
        ST_CAP_DR  = 4'd3,
        ST_SH_DR   = 4'd4,
        ST_EX1_DR  = 4'd5,
        ST_PA_DR   = 4'd6,
        ST_EX2_DR  = 4'd7,
        ST_UP_DR   = 4'd8,
        ST_SEL_IR  = 4'd9,
        ST_CAP_IR  = 4'd10,
        ST_SH_IR   = 4'd11,
        ST_EX1_IR  = 4'd12,
        ST_PA_IR   = 4'd13,
        ST_EX2_IR  = 4'd14,
        ST_UP_IR   = 4'd15
    } tap_state_e;

    localparam int unsigned IR_W = 3;

    localparam logic [IR_W-1:0] OP_ISOLATE_CAP = 3'b000;
    localparam logic [IR_W-1:0] OP_IDENT       = 3'b001;
    localparam logic [IR_W-1:0] OP_HIZ_SAMPLE  = 3'b010;
    localparam logic [IR_W-1:0] OP_SAMPLE      = 3'b100;
    localparam logic [IR_W-1:0] OP_PASS        = 3'b111;
    localparam logic [IR_W-1:0] IR_CAPTURE_PAT = 3'b001;

    typedef enum logic [1:0] {
        PATH_PASS  = 2'd0,
        PATH_IDENT = 2'd1,
        PATH_RING  = 2'd2
    } dr_path_e;

    // Maps an instruction code to the data register it selects.
    function automatic dr_path_e path_of(input logic [IR_W-1:0] op);
        case (op)
            OP_IDENT:                               return PATH_IDENT;
            OP_ISOLATE_CAP, OP_HIZ_SAMPLE, OP_SAMPLE: return PATH_RING;
            default:                                return PATH_PASS;
        endcase
    endfunction

    // True for the instructions that isolate the memory outputs.
    function automatic logic isolates(input logic [IR_W-1:0] op);
        return (op == OP_ISOLATE_CAP) || (op == OP_HIZ_SAMPLE);
    endfunction

endpackage

// File: rtl/scan_fsm.sv
// Sixteen-state test controller.
// Moves on every rising tck according to tms; a low trst_n forces the reset state.
// Also gives the next state, so the instruction register can react on entry to reset.
module scan_fsm
    import scan_pkg::*;
(
    input  logic       tck,
    input  logic       trst_n,
    input  logic       tms,
    output tap_state_e state,
    output tap_state_e nxt
);

    // Next-state function of the controller.
    always_comb begin
        case (state)
            ST_RESET:  nxt = tms ? ST_RESET  : ST_IDLE;
            ST_IDLE:   nxt = tms ? ST_SEL_DR : ST_IDLE;
            ST_SEL_DR: nxt = tms ? ST_SEL_IR : ST_CAP_DR;
            ST_CAP_DR: nxt = tms ? ST_EX1_DR : ST_SH_DR;
            ST_SH_DR:  nxt = tms ? ST_EX1_DR : ST_SH_DR;
            ST_EX1_DR: nxt = tms ? ST_UP_DR  : ST_PA_DR;
            ST_PA_DR:  nxt = tms ? ST_EX2_DR : ST_PA_DR;
            ST_EX2_DR: nxt = tms ? ST_UP_DR  : ST_SH_DR;
            ST_UP_DR:  nxt = tms ? ST_SEL_DR : ST_IDLE;
            ST_SEL_IR: nxt = tms ? ST_RESET  : ST_CAP_IR;
            ST_CAP_IR: nxt = tms ? ST_EX1_IR : ST_SH_IR;
            ST_SH_IR:  nxt = tms ? ST_EX1_IR : ST_SH_IR;
            ST_EX1_IR: nxt = tms ? ST_UP_IR  : ST_PA_IR;
            ST_PA_IR:  nxt = tms ? ST_EX2_IR : ST_PA_IR;
            ST_EX2_IR: nxt = tms ? ST_UP_IR  : ST_SH_IR;
            ST_UP_IR:  nxt = tms ? ST_SEL_DR : ST_IDLE;
            default:   nxt = ST_RESET;
        endcase
    end

    // State register with synchronous active-low reset.
    always_ff @(posedge tck) begin
        if (!trst_n) state <= ST_RESET;
        else         state <= nxt;
    end

endmodule

// File: rtl/scan_ir.sv
// Instruction shifter and current instruction.
// The shifter loads a fixed pattern in Capture-IR and shifts toward bit 0.
// The current instruction is loaded from the shifter only on leaving Update-IR,
// and is set to identify whenever the controller enters or stays in reset.
module scan_ir
    import scan_pkg::*;
(
    input  logic            tck,
    input  logic            trst_n,
    input  logic            tdi,
    input  tap_state_e      state,
    input  tap_state_e      nxt,
    output logic [IR_W-1:0] ir_shift,
    output logic [IR_W-1:0] ir_cur
);

    // Capture and shift of the instruction shifter.
    always_ff @(posedge tck) begin
        if (!trst_n)                ir_shift <= IR_CAPTURE_PAT;
        else if (state == ST_CAP_IR) ir_shift <= IR_CAPTURE_PAT;
        else if (state == ST_SH_IR)  ir_shift <= {tdi, ir_shift[IR_W-1:1]};
    end

    // Current instruction: reset to identify, updated only from Update-IR.
    always_ff @(posedge tck) begin
        if (!trst_n || nxt == ST_RESET) ir_cur <= OP_IDENT;
        else if (state == ST_UP_IR)     ir_cur <= ir_shift;
    end

endmodule

// File: rtl/scan_dr.sv
// Data registers: 1-bit bypass, identification word, boundary register.
// All capture in Capture-DR and shift toward bit 0 in Shift-DR; only the
// register chosen by the current instruction moves. No parallel output exists,
// so shifted-in boundary data never reaches a pin.
module scan_dr
    import scan_pkg::*;
#(
    parameter int unsigned BSR_LEN    = 75,
    parameter logic [3:0]  REV_CODE   = 4'b0000,
    parameter logic [4:0]  DEPTH_CODE = 5'b00111,
    parameter logic [4:0]  WIDTH_CODE = 5'b00011,
    parameter logic [5:0]  DEV_FIELD  = 6'b000000,
    parameter logic [10:0] MFR_CODE   = 11'b00000101100
) (
    input  logic               tck,
    input  logic               trst_n,
    input  logic               tdi,
    input  tap_state_e         state,
    input  logic [IR_W-1:0]    ir_cur,
    input  logic [BSR_LEN-1:0] io_ring,
    output logic               dr_tdo,
    output logic               ring_cap
);

    localparam int unsigned ID_W = 32;
    localparam logic [ID_W-1:0] ID_WORD =
        {REV_CODE, DEPTH_CODE, WIDTH_CODE, DEV_FIELD, MFR_CODE, 1'b1};

    dr_path_e           path;
    logic               pass_q;
    logic [ID_W-1:0]    id_q;
    logic [BSR_LEN-1:0] ring_q;

    // Path selection from the current instruction.
    always_comb path = path_of(ir_cur);

    // Bypass stage: captures 0, shifts tdi.
    always_ff @(posedge tck) begin
        if (!trst_n)                                   pass_q <= 1'b0;
        else if (path == PATH_PASS && state == ST_CAP_DR) pass_q <= 1'b0;
        else if (path == PATH_PASS && state == ST_SH_DR)  pass_q <= tdi;
    end

    // Identification word: loads the constant, shifts toward bit 0.
    always_ff @(posedge tck) begin
        if (!trst_n)                                    id_q <= '0;
        else if (path == PATH_IDENT && state == ST_CAP_DR) id_q <= ID_WORD;
        else if (path == PATH_IDENT && state == ST_SH_DR)  id_q <= {tdi, id_q[ID_W-1:1]};
    end

    // Boundary register: snapshots the I/O ring, shifts toward bit 0.
    always_ff @(posedge tck) begin
        if (!trst_n)                                   ring_q <= '0;
        else if (path == PATH_RING && state == ST_CAP_DR) ring_q <= io_ring;
        else if (path == PATH_RING && state == ST_SH_DR)  ring_q <= {tdi, ring_q[BSR_LEN-1:1]};
    end

    // Serial output of the selected register.
    always_comb begin
        case (path)
            PATH_IDENT: dr_tdo = id_q[0];
            PATH_RING:  dr_tdo = ring_q[0];
            default:    dr_tdo = pass_q;
        endcase
    end

    // Capture strobe toward the core.
    always_comb ring_cap = (path == PATH_RING) && (state == ST_CAP_DR);

endmodule

// File: rtl/scan_port_chk.sv
// Checker for the test access port; bound to the top module below.
module scan_port_chk
    import scan_pkg::*;
(
    input logic            tck,
    input logic            trst_n,
    input tap_state_e      state,
    input logic [IR_W-1:0] ir_cur,
    input logic [IR_W-1:0] ir_shift,
    input logic            hiz_force,
    input logic            tdo_en,
    input logic            bsr_capture
);

    // R1: reset puts the controller in Test-Logic-Reset
    a_r1_reset_state: assert property (@(posedge tck)
        !trst_n |=> state == ST_RESET);

    // R2: the reset state always holds the identify instruction
    a_r2_reset_ident: assert property (@(posedge tck) disable iff (!trst_n)
        state == ST_RESET |-> ir_cur == OP_IDENT);

    // R3: Capture-IR loads the fixed pattern
    a_r3_ir_capture: assert property (@(posedge tck) disable iff (!trst_n)
        state == ST_CAP_IR |=> ir_shift == IR_CAPTURE_PAT);

    // R4: the instruction only changes from Update-IR or on entry to reset
    a_r4_ir_update_only: assert property (@(posedge tck) disable iff (!trst_n)
        !$stable(ir_cur) |-> ($past(state) == ST_UP_IR || state == ST_RESET));

    // R8: output isolation can only begin from Update-IR
    a_r8_hiz_from_update: assert property (@(posedge tck) disable iff (!trst_n)
        $rose(hiz_force) |-> $past(state) == ST_UP_IR);

    // R9: output enable seen at rising edges matches the shift states
    a_r9_tdo_en_shift: assert property (@(posedge tck) disable iff (!trst_n)
        tdo_en == (state == ST_SH_DR || state == ST_SH_IR));

    // R10: boundary capture strobe only in Capture-DR
    a_r10_cap_strobe: assert property (@(posedge tck) disable iff (!trst_n)
        bsr_capture |-> state == ST_CAP_DR);

endmodule

// File: rtl/scan_port.sv
// Top of the memory test access port.
// Wires the controller, instruction register and data registers. tdo and its
// enable are retimed to the falling edge of tck. hiz_force follows the current
// instruction. Assumes tck is the only clock and trst_n is synchronous to it.
module scan_port
    import scan_pkg::*;
#(
    parameter int unsigned BSR_LEN    = 75,
    parameter logic [3:0]  REV_CODE   = 4'b0000,
    parameter logic [4:0]  DEPTH_CODE = 5'b00111,
    parameter logic [4:0]  WIDTH_CODE = 5'b00011,
    parameter logic [5:0]  DEV_FIELD  = 6'b000000,
    parameter logic [10:0] MFR_CODE   = 11'b00000101100
) (
    input  logic               tck,
    input  logic               trst_n,
    input  logic               tms,
    input  logic               tdi,
    input  logic [BSR_LEN-1:0] io_ring,
    output logic               tdo,
    output logic               tdo_en,
    output logic               hiz_force,
    output logic               bsr_capture
);

    tap_state_e      state;
    tap_state_e      nxt;
    logic [IR_W-1:0] ir_shift;
    logic [IR_W-1:0] ir_cur;
    logic            dr_tdo;
    logic            tdo_q;
    logic            en_q;

    scan_fsm u_fsm (
        .tck    (tck),
        .trst_n (trst_n),
        .tms    (tms),
        .state  (state),
        .nxt    (nxt)
    );

    scan_ir u_ir (
        .tck      (tck),
        .trst_n   (trst_n),
        .tdi      (tdi),
        .state    (state),
        .nxt      (nxt),
        .ir_shift (ir_shift),
        .ir_cur   (ir_cur)
    );

    scan_dr #(
        .BSR_LEN    (BSR_LEN),
        .REV_CODE   (REV_CODE),
        .DEPTH_CODE (DEPTH_CODE),
        .WIDTH_CODE (WIDTH_CODE),
        .DEV_FIELD  (DEV_FIELD),
        .MFR_CODE   (MFR_CODE)
    ) u_dr (
        .tck      (tck),
        .trst_n   (trst_n),
        .tdi      (tdi),
        .state    (state),
        .ir_cur   (ir_cur),
        .io_ring  (io_ring),
        .dr_tdo   (dr_tdo),
        .ring_cap (bsr_capture)
    );

    // Falling-edge retiming of serial data and its enable.
    always_ff @(negedge tck) begin
        if (!trst_n) begin
            en_q  <= 1'b0;
            tdo_q <= 1'b0;
        end else begin
            en_q  <= (state == ST_SH_DR) || (state == ST_SH_IR);
            tdo_q <= (state == ST_SH_IR) ? ir_shift[0] : dr_tdo;
        end
    end

    // Tri-state serial output and isolation request.
    assign tdo       = en_q ? tdo_q : 1'bz;
    assign tdo_en    = en_q;
    assign hiz_force = isolates(ir_cur);

endmodule

bind scan_port scan_port_chk u_chk (
    .tck         (tck),
    .trst_n      (trst_n),
    .state       (state),
    .ir_cur      (ir_cur),
    .ir_shift    (ir_shift),
    .hiz_force   (hiz_force),
    .tdo_en      (tdo_en),
    .bsr_capture (bsr_capture)
);

// File: tb/sim_scan_port.sv
// Scoreboard bench: driver tasks queue expected serial bits, a monitor
// compares them with the observed tdo stream.
module sim_scan_port;

    localparam int BSR_LEN = 75;
    localparam logic [31:0] ID_EXP =
        {4'b0000, 5'b00111, 5'b00011, 6'b000000, 11'b00000101100, 1'b1};

    logic               tck = 1'b0;
    logic               trst_n = 1'b0;
    logic               tms = 1'b1;
    logic               tdi = 1'b0;
    logic [BSR_LEN-1:0] io_ring;
    wire                tdo;
    logic               tdo_en;
    logic               hiz_force;
    logic               bsr_capture;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    typedef struct {
        logic  bitv;
        string tag;
    } exp_t;

    exp_t exp_q[$];
    logic obs_q[$];

    scan_port u0 (
        .tck         (tck),
        .trst_n      (trst_n),
        .tms         (tms),
        .tdi         (tdi),
        .io_ring     (io_ring),
        .tdo         (tdo),
        .tdo_en      (tdo_en),
        .hiz_force   (hiz_force),
        .bsr_capture (bsr_capture)
    );

    always #10 tck = ~tck;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One tck cycle: optionally record tdo, drive inputs, pass the rising edge.
    task automatic tick(input logic m, input logic d, input bit rec);
        @(negedge tck);
        #2;
        if (rec) obs_q.push_back(tdo);
        tms = m;
        tdi = d;
        @(posedge tck);
        #1;
    endtask

    // Monitor: pops expected and observed bits and compares them in order.
    initial begin
        forever begin
            @(negedge tck);
            while (exp_q.size() > 0 && obs_q.size() > 0) begin
                exp_t e;
                logic o;
                e = exp_q.pop_front();
                o = obs_q.pop_front();
                chk(o === e.bitv, e.tag, {31'b0, o}, {31'b0, e.bitv});
            end
        end
    end

    // Load an instruction from Run-Test/Idle; the captured 001 is checked (R3).
    task automatic load_ir(input logic [2:0] code);
        logic hz_before;
        hz_before = hiz_force;
        tick(1, 0, 0);
        tick(1, 0, 0);
        tick(0, 0, 0);
        tick(0, 0, 0);
        exp_q.push_back('{1'b1, "R3"});
        exp_q.push_back('{1'b0, "R3"});
        exp_q.push_back('{1'b0, "R3"});
        for (int i = 0; i < 3; i++) tick(i == 2, code[i], 1);
        chk(hiz_force === hz_before, "R4", {31'b0, hiz_force}, {31'b0, hz_before});
        tick(1, 0, 0);
        tick(0, 0, 0);
    endtask

    // Scan n data bits from Run-Test/Idle, returning the capture strobe.
    task automatic scan_dr(input int n, input logic [BSR_LEN-1:0] din,
                           input logic [BSR_LEN-1:0] exp, input string tag,
                           output logic capflag);
        tick(1, 0, 0);
        tick(0, 0, 0);
        capflag = bsr_capture;
        tick(0, 0, 0);
        for (int i = 0; i < n; i++) exp_q.push_back('{exp[i], tag});
        for (int i = 0; i < n; i++) begin
            tick(i == n - 1, din[i], 1);
            if (i == 0) chk(tdo_en === 1'b1, "R9", {31'b0, tdo_en}, 32'd1);
        end
        tick(1, 0, 0);
        tick(0, 0, 0);
    endtask

    initial begin
        logic               cap;
        logic [BSR_LEN-1:0] ring_a;
        logic [BSR_LEN-1:0] ring_b;
        logic [7:0]         pass_in;
        logic [BSR_LEN-1:0] pass_exp;
        ring_a  = {11'h5A3, 64'hDEAD_BEEF_0123_4567};
        ring_b  = {11'h0C9, 64'h8421_7E3C_F00F_1234};
        io_ring = ring_a;
        pass_in = 8'b1011_0010;
        pass_exp = '0;
        for (int i = 1; i < 8; i++) pass_exp[i] = pass_in[i-1];

        repeat (3) @(posedge tck);
        #3;
        chk(tdo_en === 1'b0, "R1", {31'b0, tdo_en}, 32'd0);
        chk(tdo === 1'bz, "R1", {31'b0, tdo}, 32'd0);
        chk(hiz_force === 1'b0, "R1", {31'b0, hiz_force}, 32'd0);
        @(negedge tck);
        trst_n = 1'b1;
        tick(0, 0, 0);

        // R5: identify is selected after reset
        scan_dr(32, '0, {43'b0, ID_EXP}, "R5", cap);
        chk(cap === 1'b0, "R10", {31'b0, cap}, 32'd0);

        // R6: bypass and an unused code
        load_ir(3'b111);
        chk(hiz_force === 1'b0, "R6", {31'b0, hiz_force}, 32'd0);
        scan_dr(8, {67'b0, pass_in}, pass_exp, "R6", cap);
        load_ir(3'b101);
        chk(hiz_force === 1'b0, "R6", {31'b0, hiz_force}, 32'd0);
        scan_dr(8, {67'b0, pass_in}, pass_exp, "R6", cap);

        // R7: sample without isolation
        load_ir(3'b100);
        chk(hiz_force === 1'b0, "R7", {31'b0, hiz_force}, 32'd0);
        scan_dr(BSR_LEN, '0, ring_a, "R7", cap);
        chk(cap === 1'b1, "R10", {31'b0, cap}, 32'd1);

        // R8: isolating instructions
        io_ring = ring_b;
        load_ir(3'b000);
        chk(hiz_force === 1'b1, "R8", {31'b0, hiz_force}, 32'd1);
        scan_dr(BSR_LEN, ring_a, ring_b, "R8", cap);
        chk(cap === 1'b1, "R10", {31'b0, cap}, 32'd1);
        io_ring = ~ring_b;
        load_ir(3'b010);
        chk(hiz_force === 1'b1, "R8", {31'b0, hiz_force}, 32'd1);
        scan_dr(BSR_LEN, '0, ~ring_b, "R8", cap);

        // R9: idle state keeps tdo released
        @(negedge tck);
        #3;
        chk(tdo_en === 1'b0, "R9", {31'b0, tdo_en}, 32'd0);
        chk(tdo === 1'bz, "R9", {31'b0, tdo}, 32'd0);

        // R2: five ones from Pause-DR reach reset and restore identify
        tick(1, 0, 0);
        tick(0, 0, 0);
        tick(0, 0, 0);
        tick(1, 0, 0);
        tick(0, 0, 0);
        for (int i = 0; i < 4; i++) tick(1, 0, 0);
        chk(hiz_force === 1'b1, "R2", {31'b0, hiz_force}, 32'd1);
        tick(1, 0, 0);
        chk(hiz_force === 1'b0, "R2", {31'b0, hiz_force}, 32'd0);
        tick(0, 0, 0);
        scan_dr(32, '0, {43'b0, ID_EXP}, "R2", cap);

        repeat (3) @(negedge tck);
        chk(exp_q.size() == 0 && obs_q.size() == 0, "R9",
            exp_q.size() + obs_q.size(), 32'd0);
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge tck);
        if (!done) begin
            done = 1;
            chk(1'b0, "R1 watchdog", 32'd0, 32'd1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule